// File: doc/BRIEF.md
# Alarm and Frequency Output Controller

This block decides what an active-low, open-drain interrupt/clock pin does. The pin has three uses. It can carry a square wave picked from a set of divided-clock taps. It can give a fixed-width low pulse for each alarm match. It can stay low from an alarm match until software clears the alarm status bit. A clock selection takes priority over both alarm behaviours. A dedicated control bit can silence the pin completely while the device runs from its backup battery.

The block also produces one-cycle clear strobes for four status flags: alarm, low main supply, upper low-battery threshold and lower low-battery threshold. These strobes fire when a status-register read has completed with a STOP and automatic clearing is enabled. The control fields are captured from a configuration bus on a load strobe. Until the first load, the pin stays released. The alarm comparator, the oscillator and the clock divider are outside this block. It receives their results as a match pulse, a slow timing tick and a tap vector.

Top module: `irq_fout_ctrl`

## Requirements
- R1: After reset, and until the first `cfg_load_i` strobe, `pin_pull_low_o` is 0 (pin released) and every clear strobe is 0. Alarm events and read completions in that period have no effect.
- R2: With interrupt mode (`cfg_irq_mode_i`=1) and frequency select 0, an alarm event pulls the pin low one cycle after it is sampled. The pin stays low until exactly `PULSE_TICKS` `tick_i` pulses have been seen, then it is released one cycle later.
- R3: An alarm event that arrives while an interrupt pulse is running neither restarts nor lengthens that pulse.
- R4: With standard mode (`cfg_irq_mode_i`=0) and frequency select 0, an alarm event pulls the pin low. The pin stays low while `alarm_stat_i` is 1 and is released two cycles after `alarm_stat_i` drops to 0.
- R5: With `cfg_bat_quiet_i`=1 and `bat_mode_i`=1, the pin is released one cycle later, whatever the alarm or frequency state. The alarm state that is held resurfaces when `bat_mode_i` returns to 0.
- R6: With `cfg_bat_quiet_i`=0, alarm signalling on the pin works unchanged while `bat_mode_i`=1.
- R7: A nonzero frequency select n (1 to `NTAPS`) makes the pin follow tap n-1 one cycle later (`pin_pull_low_o` = NOT `taps_i[n-1]`). Code 1 is the fastest tap and the reset value of the field. This overrides any alarm signalling.
- R8: Frequency select 0 hands the pin back to the alarm logic. An alarm state that was held while the clock was selected appears on the pin again.
- R9: With `cfg_auto_clr_i`=1, each `stat_rd_done_i` pulse raises all four clear strobes for exactly one cycle, one cycle later. With `cfg_auto_clr_i`=0, no strobe is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_load_i | input | 1 | Strobe capturing the configuration fields |
| cfg_irq_mode_i | input | 1 | 1 = pulse per alarm, 0 = hold until status cleared |
| cfg_auto_clr_i | input | 1 | 1 = clear status flags after a completed status read |
| cfg_bat_quiet_i | input | 1 | 1 = release the pin during battery backup |
| cfg_fsel_i | input | 4 | Frequency select, 0 = off, n = tap n-1 |
| alarm_evt_i | input | 1 | One-cycle alarm match event |
| alarm_stat_i | input | 1 | Current value of the alarm status flag |
| bat_mode_i | input | 1 | 1 while running from the backup battery |
| tick_i | input | 1 | Fixed-rate timing tick for the interrupt pulse |
| taps_i | input | NTAPS | Divided-clock taps, bit 0 fastest |
| stat_rd_done_i | input | 1 | Status register read finished with STOP |
| pin_pull_low_o | output | 1 | 1 = drive the open-drain pin low |
| clr_alarm_o | output | 1 | Clear strobe for the alarm flag |
| clr_lowsup_o | output | 1 | Clear strobe for the low-supply flag |
| clr_lbat_hi_o | output | 1 | Clear strobe for the upper low-battery flag |
| clr_lbat_lo_o | output | 1 | Clear strobe for the lower low-battery flag |

## Verification
A corrupted pulse counter shows up at the pin as an interrupt pulse whose length differs from `PULSE_TICKS` ticks. This is visible at the release edge, at most 250 ticks after the event. A stuck standard-mode latch keeps the pin low past the status clear, and the fault appears two cycles after `alarm_stat_i` falls. A wrong priority among battery silence, clock selection and alarm, or a wrong tap index, corrupts the pin one cycle after the configuration or the tap changes. A bad auto-clear gate shows up on the strobes in the cycle after the read completes.

// File: rtl/irqf_pkg.sv
package irqf_pkg;
  localparam int unsigned FSEL_W = 4;

  typedef struct packed {
    logic              irq_mode;
    logic              auto_clr;
    logic              bat_quiet;
    logic [FSEL_W-1:0] fsel;
  } irqf_cfg_t;

  localparam irqf_cfg_t CFG_RESET = '{irq_mode: 1'b0, auto_clr: 1'b0,
                                      bat_quiet: 1'b0, fsel: 4'h1};
endpackage

// File: rtl/irqf_cfg_reg.sv
module irqf_cfg_reg
  import irqf_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      load_i,
  input  irqf_cfg_t cfg_i,
  output irqf_cfg_t cfg_o,
  output logic      valid_o
);
  irqf_cfg_t cfg_q, cfg_d;
  logic      valid_q, valid_d;

  always_comb begin
    cfg_d   = cfg_q;
    valid_d = valid_q;
    if (load_i) begin
      cfg_d   = cfg_i;
      valid_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q   <= CFG_RESET;
      valid_q <= 1'b0;
    end else begin
      cfg_q   <= cfg_d;
      valid_q <= valid_d;
    end
  end

  assign cfg_o   = cfg_q;
  assign valid_o = valid_q;
endmodule

// File: rtl/irqf_pulse_timer.sv
module irqf_pulse_timer #(
  parameter int unsigned TICKS = 250,
  localparam int unsigned CNT_W = $clog2(TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire_i,
  input  logic             tick_i,
  output logic             active_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             idle;

  assign idle = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (idle && fire_i)
      cnt_d = CNT_W'(TICKS);
    else if (!idle && tick_i)
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign active_o = !idle;
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/irqf_tap_mux.sv
module irqf_tap_mux
  import irqf_pkg::*;
#(
  parameter int unsigned NTAPS = 15
) (
  input  logic [NTAPS-1:0]  taps_i,
  input  logic [FSEL_W-1:0] fsel_i,
  output logic              en_o,
  output logic              level_o
);
  logic [NTAPS-1:0] hit;

  for (genvar g = 0; g < NTAPS; g++) begin : g_hit
    assign hit[g] = (fsel_i == FSEL_W'(g + 1));
  end

  assign en_o    = (fsel_i != '0);
  assign level_o = ~|(hit & ~taps_i);
endmodule

// File: rtl/irq_fout_ctrl.sv
module irq_fout_ctrl
  import irqf_pkg::*;
#(
  parameter int unsigned NTAPS       = 15,
  parameter int unsigned PULSE_TICKS = 250,
  localparam int unsigned CNT_W      = $clog2(PULSE_TICKS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_load_i,
  input  logic             cfg_irq_mode_i,
  input  logic             cfg_auto_clr_i,
  input  logic             cfg_bat_quiet_i,
  input  logic [3:0]       cfg_fsel_i,
  input  logic             alarm_evt_i,
  input  logic             alarm_stat_i,
  input  logic             bat_mode_i,
  input  logic             tick_i,
  input  logic [NTAPS-1:0] taps_i,
  input  logic             stat_rd_done_i,
  output logic             pin_pull_low_o,
  output logic             clr_alarm_o,
  output logic             clr_lowsup_o,
  output logic             clr_lbat_hi_o,
  output logic             clr_lbat_lo_o
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  irqf_cfg_t cfg_in, cfg_q;
  logic      cfg_ok;

  assign cfg_in = '{irq_mode: cfg_irq_mode_i, auto_clr: cfg_auto_clr_i,
                    bat_quiet: cfg_bat_quiet_i, fsel: cfg_fsel_i};

  irqf_cfg_reg u_cfg (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .load_i (cfg_load_i),
    .cfg_i  (cfg_in),
    .cfg_o  (cfg_q),
    .valid_o(cfg_ok)
  );

  logic             pulse_fire, pulse_on;
  logic [CNT_W-1:0] pulse_cnt;

  assign pulse_fire = cfg_ok && cfg_q.irq_mode && alarm_evt_i;

  irqf_pulse_timer #(.TICKS(PULSE_TICKS)) u_pulse (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .fire_i  (pulse_fire),
    .tick_i  (tick_i),
    .active_o(pulse_on),
    .cnt_o   (pulse_cnt)
  );

  logic freq_en, freq_level;

  irqf_tap_mux #(.NTAPS(NTAPS)) u_mux (
    .taps_i (taps_i),
    .fsel_i (cfg_q.fsel),
    .en_o   (freq_en),
    .level_o(freq_level)
  );

  // standard-mode hold latch and output registers
  logic       hold_q, hold_d;
  logic       pin_q, pin_d;
  logic [3:0] clr_q, clr_d;

  always_comb begin
    hold_d = (cfg_ok && !cfg_q.irq_mode && alarm_evt_i) || (hold_q && alarm_stat_i);

    if (!cfg_ok)
      pin_d = 1'b0;
    else if (bat_mode_i && cfg_q.bat_quiet)
      pin_d = 1'b0;
    else if (freq_en)
      pin_d = !freq_level;
    else if (cfg_q.irq_mode)
      pin_d = pulse_on;
    else
      pin_d = hold_q;

    clr_d = {4{cfg_ok && cfg_q.auto_clr && stat_rd_done_i}};
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      hold_q <= 1'b0;
      pin_q  <= 1'b0;
      clr_q  <= 4'b0;
    end else begin
      hold_q <= hold_d;
      pin_q  <= pin_d;
      clr_q  <= clr_d;
    end
  end

  assign pin_pull_low_o = pin_q;
  assign clr_alarm_o    = clr_q[0];
  assign clr_lowsup_o   = clr_q[1];
  assign clr_lbat_hi_o  = clr_q[2];
  assign clr_lbat_lo_o  = clr_q[3];
endmodule

// File: rtl/irqf_checker.sv
module irqf_checker #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_load_i,
  input logic             bat_mode_i,
  input logic             bat_quiet,
  input logic             auto_clr,
  input logic             cfg_ok,
  input logic             stat_rd_done_i,
  input logic             pin,
  input logic [3:0]       clr,
  input logic [CNT_W-1:0] pulse_cnt
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_q <= 1'b0;
    else if (cfg_load_i) seen_q <= 1'b1;
  end

  // R1: no drive before any configuration load
  assert_released_unconfigured_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !pin);

  // R3: running pulse counter never moves upward
  assert_no_stretch_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pulse_cnt != '0) |=> (pulse_cnt <= $past(pulse_cnt)));

  // R5: battery silence releases the pin next cycle
  assert_bat_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bat_mode_i && bat_quiet) |=> !pin);

  // R9: completed read with auto clear gives all strobes
  assert_auto_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_done_i && cfg_ok && auto_clr) |=> (clr == 4'hF));

  // R9: no strobe without an enabled read completion
  assert_no_spurious_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(stat_rd_done_i && cfg_ok && auto_clr) |=> (clr == 4'h0));
endmodule

bind irq_fout_ctrl irqf_checker #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_load_i    (cfg_load_i),
  .bat_mode_i    (bat_mode_i),
  .bat_quiet     (cfg_q.bat_quiet),
  .auto_clr      (cfg_q.auto_clr),
  .cfg_ok        (cfg_ok),
  .stat_rd_done_i(stat_rd_done_i),
  .pin           (pin_pull_low_o),
  .clr           ({clr_lbat_lo_o, clr_lbat_hi_o, clr_lowsup_o, clr_alarm_o}),
  .pulse_cnt     (pulse_cnt)
);

// File: tb/test_irq_fout_ctrl.sv
module test_irq_fout_ctrl;
  localparam int NTAPS = 15;
  localparam int PT    = 250;

  logic clk = 1'b0;
  logic rst_n;
  logic cfg_load, cfg_irq, cfg_auto, cfg_quiet;
  logic [3:0] cfg_fsel;
  logic alarm_evt, alarm_stat, bat_mode, tick, rd_done;
  logic [NTAPS-1:0] taps;
  logic pin, c_al, c_ls, c_bh, c_bl;

  int checks   = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  irq_fout_ctrl i_irq_fout_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_load_i(cfg_load), .cfg_irq_mode_i(cfg_irq),
    .cfg_auto_clr_i(cfg_auto), .cfg_bat_quiet_i(cfg_quiet), .cfg_fsel_i(cfg_fsel),
    .alarm_evt_i(alarm_evt), .alarm_stat_i(alarm_stat), .bat_mode_i(bat_mode),
    .tick_i(tick), .taps_i(taps), .stat_rd_done_i(rd_done),
    .pin_pull_low_o(pin), .clr_alarm_o(c_al), .clr_lowsup_o(c_ls),
    .clr_lbat_hi_o(c_bh), .clr_lbat_lo_o(c_bl));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic irq, input logic auto_c, input logic quiet, input logic [3:0] fs);
    cfg_irq = irq; cfg_auto = auto_c; cfg_quiet = quiet; cfg_fsel = fs;
    cfg_load = 1'b1; cyc(1); cfg_load = 1'b0; cyc(1);
  endtask

  task automatic evt();
    alarm_evt = 1'b1; cyc(1); alarm_evt = 1'b0; cyc(1);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1; cyc(1); tick = 1'b0; cyc(1);
    end
  endtask

  function automatic int clr_vec();
    return int'({c_bl, c_bh, c_ls, c_al});
  endfunction

  task automatic t_reset();
    chk("R1 pin after reset", int'(pin), 0);
    chk("R1 strobes after reset", clr_vec(), 0);
    alarm_stat = 1'b1; evt();
    chk("R1 alarm before config", int'(pin), 0);
    rd_done = 1'b1; cyc(1); rd_done = 1'b0;
    chk("R1 read before config", clr_vec(), 0);
    alarm_stat = 1'b0; cyc(2);
  endtask

  task automatic t_irq_pulse();
    load(1'b1, 1'b0, 1'b0, 4'h0);
    evt();
    chk("R2 pulse starts", int'(pin), 1);
    ticks(PT - 1);
    chk("R2 low before last tick", int'(pin), 1);
    ticks(1);
    chk("R2 released after last tick", int'(pin), 0);
  endtask

  task automatic t_no_stretch();
    evt();
    ticks(100);
    evt();
    ticks(PT - 101);
    chk("R3 still low", int'(pin), 1);
    ticks(1);
    chk("R3 not stretched", int'(pin), 0);
  endtask

  task automatic t_std();
    load(1'b0, 1'b0, 1'b0, 4'h0);
    alarm_stat = 1'b1; evt();
    chk("R4 held low", int'(pin), 1);
    ticks(PT + 5); cyc(10);
    chk("R4 still held", int'(pin), 1);
    alarm_stat = 1'b0; cyc(2);
    chk("R4 released on status clear", int'(pin), 0);
  endtask

  task automatic t_bat_quiet();
    load(1'b0, 1'b0, 1'b1, 4'h0);
    alarm_stat = 1'b1; evt();
    chk("R5 low before battery", int'(pin), 1);
    bat_mode = 1'b1; cyc(1);
    chk("R5 silent in battery", int'(pin), 0);
    load(1'b0, 1'b0, 1'b1, 4'h1); taps[0] = 1'b0; cyc(2);
    chk("R5 clock silent in battery", int'(pin), 0);
    load(1'b0, 1'b0, 1'b1, 4'h0);
    bat_mode = 1'b0; cyc(1);
    chk("R5 alarm resurfaces", int'(pin), 1);
    alarm_stat = 1'b0; cyc(2);
    taps[0] = 1'b1;
  endtask

  task automatic t_bat_active();
    load(1'b1, 1'b0, 1'b0, 4'h0);
    bat_mode = 1'b1; cyc(1);
    evt();
    chk("R6 pulse in battery", int'(pin), 1);
    ticks(PT); cyc(1);
    chk("R6 pulse ends", int'(pin), 0);
    bat_mode = 1'b0;
  endtask

  task automatic t_freq();
    load(1'b0, 1'b0, 1'b0, 4'h1);
    taps = '1; taps[0] = 1'b0; cyc(1);
    chk("R7 tap0 low", int'(pin), 1);
    taps[0] = 1'b1; cyc(1);
    chk("R7 tap0 high", int'(pin), 0);
    load(1'b0, 1'b0, 1'b0, 4'h4);
    taps = '0; taps[3] = 1'b1; cyc(1);
    chk("R7 code 4 uses tap3 high", int'(pin), 0);
    taps[3] = 1'b0; taps[0] = 1'b1; cyc(1);
    chk("R7 code 4 uses tap3 low", int'(pin), 1);
    taps = '1;
    alarm_stat = 1'b1; evt(); cyc(1);
    chk("R7 clock overrides alarm", int'(pin), 0);
    load(1'b0, 1'b0, 1'b0, 4'h0); cyc(1);
    chk("R8 select 0 returns alarm", int'(pin), 1);
    alarm_stat = 1'b0; cyc(2);
    chk("R8 alarm cleared", int'(pin), 0);
  endtask

  task automatic t_autoclr();
    load(1'b0, 1'b1, 1'b0, 4'h0);
    rd_done = 1'b1; cyc(1); rd_done = 1'b0;
    chk("R9 all strobes", clr_vec(), 15);
    cyc(1);
    chk("R9 strobe one cycle", clr_vec(), 0);
    load(1'b0, 1'b0, 1'b0, 4'h0);
    rd_done = 1'b1; cyc(1); rd_done = 1'b0;
    chk("R9 no strobe when off", clr_vec(), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_load = 1'b0; cfg_irq = 1'b0; cfg_auto = 1'b0;
    cfg_quiet = 1'b0; cfg_fsel = 4'h0; alarm_evt = 1'b0; alarm_stat = 1'b0;
    bat_mode = 1'b0; tick = 1'b0; rd_done = 1'b0; taps = '1;
    cyc(4); rst_n = 1'b1; cyc(4);
    t_reset();
    t_irq_pulse();
    t_no_stretch();
    t_std();
    t_bat_quiet();
    t_bat_active();
    t_freq();
    t_autoclr();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule